// File: doc/BRIEF.md
# Display Settings Command Decoder

This block sits behind the host byte interface of a small graphic display controller. Every byte reaches it as a one-cycle strobe, together with a flag that tells command bytes from pixel data. The block reads the command bytes and keeps a register file of display settings. The settings cover the address window, the remap bits, contrast, current range, start line, offset, display mode, multiplex ratio, on/off state, drive phase lengths, row period, clock divider, supply options, the analog level registers and a table of fifteen gray levels.

Many opcodes are followed by parameter bytes. A small sequencer remembers the pending opcode, how many parameter bytes are still owed and which one comes next. Each parameter byte is masked to its field width and written into place. Pixel data bytes never touch the settings, and a data byte that arrives before a command's parameters are complete abandons that command. A settings change appears on the outputs in the cycle after the strobe edge that carried the byte.

Top module: `disp_cmd_decoder`

## Requirements
- R1: After synchronous reset the outputs take these values: column window 00h/3Fh, row window 00h/4Fh, contrast 40h, current range 0 (quarter), remap 0, start line 0, offset 0, display mode 0 (normal), multiplex 4Fh, supply bits 11b, display off, phase 1 = 3, phase 2 = 5, row period 25h, divide field 1, oscillator field 0, common-high level 11h, precharge 18h, bias F0h, and every gray level 1.
- R2: The no-parameter opcodes act on their single byte. 84h/85h/86h set current range 0/1/2 (quarter/half/full). A4h/A5h/A6h/A7h set display mode 0/1/2/3 (normal/all on/all off/inverse). AEh clears display_on and AFh sets it.
- R3: Opcode 15h takes two bytes: the column start from bits 5:0, then the column end from bits 5:0. Opcode 75h takes two bytes: the row start from bits 6:0, then the row end from bits 6:0.
- R4: Each single-parameter opcode stores its byte masked to its field. 81h sets contrast [6:0]. A0h sets remap [6:0]. A1h sets start line [6:0]. A2h sets offset [6:0]. A8h sets multiplex [6:0]. ADh sets supply bits [1:0]. BEh sets the common-high level [5:0]. BCh sets precharge [7:0]. CFh sets bias [7:0]. B2h sets row period [7:0].
- R5: Opcode B1h takes one byte: bits 3:0 go to phase 1 and bits 7:4 go to phase 2. Opcode B3h takes one byte: bits 3:0 go to the divide field (ratio minus one) and bits 7:4 go to the oscillator field.
- R6: Opcode B8h takes eight bytes. Byte 0 sets level 1 from bits 2:0. Byte k (k = 1 to 7) sets level 2k from bits 2:0 and level 2k+1 from bits 6:4. Level n is output on gray_levels[3n-1:3n-3].
- R7: A strobe with wr_is_data = 1, when no parameters are pending, leaves every output unchanged.
- R8: A data strobe that arrives while parameter bytes are still owed abandons the pending opcode. Parameter bytes already received stay applied. The next command byte is decoded as an opcode.
- R9: E3h and any opcode not named in R2 to R6 change nothing and take no parameters, so the next command byte is decoded as an opcode.
- R10: A setting changes only in the cycle after a clock edge at which wr_stb = 1. In cycles without a strobe every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Byte strobe, one cycle per byte |
| wr_is_data | input | 1 | 1 = pixel data byte, 0 = command byte |
| wr_byte | input | 8 | Byte value |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| contrast | output | 7 | Contrast step |
| current_range | output | 2 | 0 quarter, 1 half, 2 full |
| remap_bits | output | 7 | Remap control bits |
| start_line | output | 7 | Display start line |
| line_offset | output | 7 | Vertical display offset |
| display_mode | output | 2 | 0 normal, 1 all on, 2 all off, 3 inverse |
| mux_ratio | output | 7 | Multiplex ratio field |
| supply_cfg | output | 2 | bit 0 converter enable, bit 1 internal common-high enable |
| display_on | output | 1 | Panel on |
| phase1_len | output | 4 | Phase 1 length |
| phase2_len | output | 4 | Phase 2 length |
| row_period | output | 8 | Clocks per row |
| clk_div | output | 4 | Divide ratio minus one |
| osc_freq | output | 4 | Oscillator frequency setting |
| com_high_level | output | 6 | Common-high voltage code |
| precharge_level | output | 8 | Precharge voltage code |
| bias_level | output | 8 | Converter bias code |
| gray_levels | output | 45 | Levels 1 to 15, three bits each, level 1 lowest |

## Verification
The assertions assume that wr_stb is a clean single-cycle pulse and that wr_is_data and wr_byte are settled at the clock edge where the strobe is sampled. They also assume that reset is held across at least one edge before traffic starts, because the hold checks compare against the state of the previous cycle. The bench drives every byte on the falling edge, holds it for exactly one rising edge and then returns the strobe to zero. It raises reset only at the start, so every strobe is seen whole, with stable flag and data.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    localparam int GRAY_N   = 15;
    localparam int GRAY_W   = 3;
    localparam int PCNT_W   = 4;
    localparam int PIDX_W   = 3;

    localparam logic [7:0] OP_COL_WIN   = 8'h15;
    localparam logic [7:0] OP_ROW_WIN   = 8'h75;
    localparam logic [7:0] OP_CONTRAST  = 8'h81;
    localparam logic [7:0] OP_REMAP     = 8'hA0;
    localparam logic [7:0] OP_START     = 8'hA1;
    localparam logic [7:0] OP_OFFSET    = 8'hA2;
    localparam logic [7:0] OP_MUX       = 8'hA8;
    localparam logic [7:0] OP_SUPPLY    = 8'hAD;
    localparam logic [7:0] OP_PHASE     = 8'hB1;
    localparam logic [7:0] OP_ROWPER    = 8'hB2;
    localparam logic [7:0] OP_CLKDIV    = 8'hB3;
    localparam logic [7:0] OP_GRAY      = 8'hB8;
    localparam logic [7:0] OP_PRECHG    = 8'hBC;
    localparam logic [7:0] OP_COMHIGH   = 8'hBE;
    localparam logic [7:0] OP_BIAS      = 8'hCF;

    typedef enum logic [1:0] {
        CR_QUARTER = 2'd0, CR_HALF = 2'd1, CR_FULL = 2'd2, CR_RSVD = 2'd3
    } cur_range_e;

    typedef enum logic [1:0] {
        DM_NORMAL = 2'd0, DM_ALL_ON = 2'd1, DM_ALL_OFF = 2'd2, DM_INVERSE = 2'd3
    } disp_mode_e;

    typedef struct packed {
        logic [5:0]                     col_start;
        logic [5:0]                     col_end;
        logic [6:0]                     row_start;
        logic [6:0]                     row_end;
        logic [6:0]                     contrast;
        cur_range_e                     cur_range;
        logic [6:0]                     remap;
        logic [6:0]                     start_line;
        logic [6:0]                     offset;
        disp_mode_e                     mode;
        logic [6:0]                     mux;
        logic [1:0]                     supply;
        logic                           on;
        logic [3:0]                     ph1;
        logic [3:0]                     ph2;
        logic [7:0]                     row_period;
        logic [3:0]                     div;
        logic [3:0]                     osc;
        logic [5:0]                     com_high;
        logic [7:0]                     precharge;
        logic [7:0]                     bias;
        logic [GRAY_N-1:0][GRAY_W-1:0]  gray;
    } disp_cfg_t;

    function automatic logic [PCNT_W-1:0] param_count(input logic [7:0] op);
        case (op)
            OP_COL_WIN, OP_ROW_WIN:                          return 4'd2;
            OP_GRAY:                                         return 4'd8;
            OP_CONTRAST, OP_REMAP, OP_START, OP_OFFSET,
            OP_MUX, OP_SUPPLY, OP_PHASE, OP_ROWPER,
            OP_CLKDIV, OP_PRECHG, OP_COMHIGH, OP_BIAS:       return 4'd1;
            default:                                         return 4'd0;
        endcase
    endfunction

    function automatic disp_cfg_t cfg_reset();
        disp_cfg_t c;
        c.col_start  = 6'h00;
        c.col_end    = 6'h3F;
        c.row_start  = 7'h00;
        c.row_end    = 7'h4F;
        c.contrast   = 7'h40;
        c.cur_range  = CR_QUARTER;
        c.remap      = 7'h00;
        c.start_line = 7'h00;
        c.offset     = 7'h00;
        c.mode       = DM_NORMAL;
        c.mux        = 7'h4F;
        c.supply     = 2'b11;
        c.on         = 1'b0;
        c.ph1        = 4'd3;
        c.ph2        = 4'd5;
        c.row_period = 8'h25;
        c.div        = 4'd1;
        c.osc        = 4'd0;
        c.com_high   = 6'h11;
        c.precharge  = 8'h18;
        c.bias       = 8'hF0;
        for (int i = 0; i < GRAY_N; i++) c.gray[i] = 3'd1;
        return c;
    endfunction

endpackage

// File: rtl/disp_cmd_seq.sv
module disp_cmd_seq
    import disp_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              is_data,
    input  logic [7:0]        din,
    output logic              imm_valid,
    output logic              prm_valid,
    output logic [7:0]        op_out,
    output logic [PIDX_W-1:0] idx_out
);

    logic [7:0]        pend_op;
    logic [PCNT_W-1:0] left;
    logic [PIDX_W-1:0] idx;
    logic              cmd_stb;
    logic              in_param;

    always_comb begin
        cmd_stb   = stb && !is_data;
        in_param  = (left != '0);
        imm_valid = cmd_stb && !in_param;
        prm_valid = cmd_stb && in_param;
        op_out    = in_param ? pend_op : din;
        idx_out   = idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_op <= 8'h00;
            left    <= '0;
            idx     <= '0;
        end else if (stb && is_data) begin
            left    <= '0;
        end else if (cmd_stb) begin
            if (in_param) begin
                left <= left - 1'b1;
                idx  <= idx + 1'b1;
            end else begin
                pend_op <= din;
                left    <= param_count(din);
                idx     <= '0;
            end
        end
    end

    assert_pend_bound_R6: assert property (@(posedge clk) disable iff (rst)
        left <= 4'd8);

    assert_data_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (stb && is_data) |=> (left == '0));

    assert_param_step_R3: assert property (@(posedge clk) disable iff (rst)
        prm_valid |=> (left == $past(left) - 1'b1));

endmodule

// File: rtl/disp_cfg_regs.sv
module disp_cfg_regs
    import disp_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              imm_valid,
    input  logic              prm_valid,
    input  logic [7:0]        op,
    input  logic [PIDX_W-1:0] idx,
    input  logic [7:0]        din,
    output disp_cfg_t         cfg
);

    logic [3:0] gray_lo;
    logic [3:0] gray_hi;

    always_comb begin
        gray_hi = {idx, 1'b0};
        gray_lo = gray_hi - 4'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_reset();
        end else if (imm_valid) begin
            case (op)
                8'h84, 8'h85, 8'h86:        cfg.cur_range <= cur_range_e'(op[1:0]);
                8'hA4, 8'hA5, 8'hA6, 8'hA7: cfg.mode      <= disp_mode_e'(op[1:0]);
                8'hAE, 8'hAF:               cfg.on        <= op[0];
                default: ;
            endcase
        end else if (prm_valid) begin
            case (op)
                OP_COL_WIN: if (idx == '0) cfg.col_start <= din[5:0];
                            else           cfg.col_end   <= din[5:0];
                OP_ROW_WIN: if (idx == '0) cfg.row_start <= din[6:0];
                            else           cfg.row_end   <= din[6:0];
                OP_CONTRAST: cfg.contrast   <= din[6:0];
                OP_REMAP:    cfg.remap      <= din[6:0];
                OP_START:    cfg.start_line <= din[6:0];
                OP_OFFSET:   cfg.offset     <= din[6:0];
                OP_MUX:      cfg.mux        <= din[6:0];
                OP_SUPPLY:   cfg.supply     <= din[1:0];
                OP_PHASE: begin
                    cfg.ph1 <= din[3:0];
                    cfg.ph2 <= din[7:4];
                end
                OP_ROWPER:   cfg.row_period <= din;
                OP_CLKDIV: begin
                    cfg.div <= din[3:0];
                    cfg.osc <= din[7:4];
                end
                OP_PRECHG:   cfg.precharge  <= din;
                OP_COMHIGH:  cfg.com_high   <= din[5:0];
                OP_BIAS:     cfg.bias       <= din;
                OP_GRAY: begin
                    if (idx == '0) begin
                        cfg.gray[0] <= din[2:0];
                    end else begin
                        cfg.gray[gray_lo] <= din[2:0];
                        cfg.gray[gray_hi] <= din[6:4];
                    end
                end
                default: ;
            endcase
        end
    end

    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(imm_valid || prm_valid) |=> (cfg == $past(cfg)));

    assert_on_only_by_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        !(imm_valid && (op[7:1] == 7'h57)) |=> $stable(cfg.on));

    assert_contrast_only_by_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        !(prm_valid && (op == OP_CONTRAST)) |=> $stable(cfg.contrast));

    assert_gray_only_by_cmd_R6: assert property (@(posedge clk) disable iff (rst)
        !(prm_valid && (op == OP_GRAY)) |=> $stable(cfg.gray));

endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
    import disp_cmd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_stb,
    input  logic                     wr_is_data,
    input  logic [7:0]               wr_byte,
    output logic [5:0]               col_start,
    output logic [5:0]               col_end,
    output logic [6:0]               row_start,
    output logic [6:0]               row_end,
    output logic [6:0]               contrast,
    output logic [1:0]               current_range,
    output logic [6:0]               remap_bits,
    output logic [6:0]               start_line,
    output logic [6:0]               line_offset,
    output logic [1:0]               display_mode,
    output logic [6:0]               mux_ratio,
    output logic [1:0]               supply_cfg,
    output logic                     display_on,
    output logic [3:0]               phase1_len,
    output logic [3:0]               phase2_len,
    output logic [7:0]               row_period,
    output logic [3:0]               clk_div,
    output logic [3:0]               osc_freq,
    output logic [5:0]               com_high_level,
    output logic [7:0]               precharge_level,
    output logic [7:0]               bias_level,
    output logic [GRAY_N*GRAY_W-1:0] gray_levels
);

    logic              imm_valid;
    logic              prm_valid;
    logic [7:0]        op;
    logic [PIDX_W-1:0] idx;
    disp_cfg_t         cfg;

    disp_cmd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .stb       (wr_stb),
        .is_data   (wr_is_data),
        .din       (wr_byte),
        .imm_valid (imm_valid),
        .prm_valid (prm_valid),
        .op_out    (op),
        .idx_out   (idx)
    );

    disp_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .imm_valid (imm_valid),
        .prm_valid (prm_valid),
        .op        (op),
        .idx       (idx),
        .din       (wr_byte),
        .cfg       (cfg)
    );

    assign col_start       = cfg.col_start;
    assign col_end         = cfg.col_end;
    assign row_start       = cfg.row_start;
    assign row_end         = cfg.row_end;
    assign contrast        = cfg.contrast;
    assign current_range   = cfg.cur_range;
    assign remap_bits      = cfg.remap;
    assign start_line      = cfg.start_line;
    assign line_offset     = cfg.offset;
    assign display_mode    = cfg.mode;
    assign mux_ratio       = cfg.mux;
    assign supply_cfg      = cfg.supply;
    assign display_on      = cfg.on;
    assign phase1_len      = cfg.ph1;
    assign phase2_len      = cfg.ph2;
    assign row_period      = cfg.row_period;
    assign clk_div         = cfg.div;
    assign osc_freq        = cfg.osc;
    assign com_high_level  = cfg.com_high;
    assign precharge_level = cfg.precharge;
    assign bias_level      = cfg.bias;
    assign gray_levels     = cfg.gray;

    assert_data_no_imm_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_is_data) |-> !(imm_valid || prm_valid));

endmodule

// File: tb/disp_cmd_decoder_bench.sv
module disp_cmd_decoder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb = 1'b0;
    logic isd = 1'b0;
    logic [7:0] byt = 8'h00;

    always #2 clk = ~clk;

    logic [5:0]  col_start, col_end;
    logic [6:0]  row_start, row_end, contrast, remap_bits, start_line, line_offset, mux_ratio;
    logic [1:0]  current_range, display_mode, supply_cfg;
    logic        display_on;
    logic [3:0]  phase1_len, phase2_len, clk_div, osc_freq;
    logic [7:0]  row_period, precharge_level, bias_level;
    logic [5:0]  com_high_level;
    logic [44:0] gray_levels;

    disp_cmd_decoder u_disp_cmd_decoder (
        .clk(clk), .rst(rst), .wr_stb(stb), .wr_is_data(isd), .wr_byte(byt),
        .col_start(col_start), .col_end(col_end), .row_start(row_start), .row_end(row_end),
        .contrast(contrast), .current_range(current_range), .remap_bits(remap_bits),
        .start_line(start_line), .line_offset(line_offset), .display_mode(display_mode),
        .mux_ratio(mux_ratio), .supply_cfg(supply_cfg), .display_on(display_on),
        .phase1_len(phase1_len), .phase2_len(phase2_len), .row_period(row_period),
        .clk_div(clk_div), .osc_freq(osc_freq), .com_high_level(com_high_level),
        .precharge_level(precharge_level), .bias_level(bias_level), .gray_levels(gray_levels)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [5:0]  e_cs = 6'h00, e_ce = 6'h3F;
    logic [6:0]  e_rs = 7'h00, e_re = 7'h4F, e_ct = 7'h40, e_rm = 7'h00, e_sl = 7'h00, e_of = 7'h00, e_mx = 7'h4F;
    logic [1:0]  e_cr = 2'd0, e_dm = 2'd0, e_sp = 2'b11;
    logic        e_on = 1'b0;
    logic [3:0]  e_p1 = 4'd3, e_p2 = 4'd5, e_dv = 4'd1, e_os = 4'd0;
    logic [7:0]  e_rp = 8'h25, e_pc = 8'h18, e_bs = 8'hF0;
    logic [5:0]  e_ch = 6'h11;
    logic [44:0] e_gr = {15{3'd1}};

    task automatic cmp(input string req, input string nm, input logic [63:0] act, input logic [63:0] exp, inout bit ok);
        if (act !== exp) begin
            $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
            ok = 1'b0;
        end
    endtask

    task automatic check_all(input string req);
        bit ok = 1'b1;
        cmp(req, "col_start", 64'(col_start), 64'(e_cs), ok);
        cmp(req, "col_end", 64'(col_end), 64'(e_ce), ok);
        cmp(req, "row_start", 64'(row_start), 64'(e_rs), ok);
        cmp(req, "row_end", 64'(row_end), 64'(e_re), ok);
        cmp(req, "contrast", 64'(contrast), 64'(e_ct), ok);
        cmp(req, "current_range", 64'(current_range), 64'(e_cr), ok);
        cmp(req, "remap_bits", 64'(remap_bits), 64'(e_rm), ok);
        cmp(req, "start_line", 64'(start_line), 64'(e_sl), ok);
        cmp(req, "line_offset", 64'(line_offset), 64'(e_of), ok);
        cmp(req, "display_mode", 64'(display_mode), 64'(e_dm), ok);
        cmp(req, "mux_ratio", 64'(mux_ratio), 64'(e_mx), ok);
        cmp(req, "supply_cfg", 64'(supply_cfg), 64'(e_sp), ok);
        cmp(req, "display_on", 64'(display_on), 64'(e_on), ok);
        cmp(req, "phase1_len", 64'(phase1_len), 64'(e_p1), ok);
        cmp(req, "phase2_len", 64'(phase2_len), 64'(e_p2), ok);
        cmp(req, "row_period", 64'(row_period), 64'(e_rp), ok);
        cmp(req, "clk_div", 64'(clk_div), 64'(e_dv), ok);
        cmp(req, "osc_freq", 64'(osc_freq), 64'(e_os), ok);
        cmp(req, "com_high_level", 64'(com_high_level), 64'(e_ch), ok);
        cmp(req, "precharge_level", 64'(precharge_level), 64'(e_pc), ok);
        cmp(req, "bias_level", 64'(bias_level), 64'(e_bs), ok);
        cmp(req, "gray_levels", 64'(gray_levels), 64'(e_gr), ok);
        n_chk++;
        if (!ok) n_bad++;
    endtask

    task automatic put(input logic d, input logic [7:0] b);
        @(negedge clk);
        stb = 1'b1; isd = d; byt = b;
        @(negedge clk);
        stb = 1'b0; isd = 1'b0; byt = 8'h00;
    endtask

    task automatic send_gray(input logic [7:0] seed, input int nbytes);
        put(1'b0, 8'hB8);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] b;
            b = 8'(((k * 3 + seed) & 7) | ((((k * 5 + seed + 2) & 7)) << 4) | 8'h88);
            put(1'b0, b);
            if (k == 0) e_gr[2:0] = b[2:0];
            else begin
                e_gr[(2*k-1)*3 +: 3] = b[2:0];
                e_gr[(2*k)*3 +: 3]   = b[6:4];
            end
        end
    endtask

    bit finished = 1'b0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=completion");
        n_chk++; n_bad++;
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R2: immediate opcodes
        for (int m = 0; m < 4; m++) begin
            put(1'b0, 8'(8'hA4 + m)); e_dm = 2'(m); check_all("R2");
        end
        for (int m = 0; m < 3; m++) begin
            put(1'b0, 8'(8'h84 + m)); e_cr = 2'(m); check_all("R2");
        end
        put(1'b0, 8'hAF); e_on = 1'b1; check_all("R2");

        // R10: output holds before the strobe edge, changes right after it
        @(negedge clk);
        stb = 1'b1; isd = 1'b0; byt = 8'hAE;
        #1;
        if (display_on !== 1'b1) begin
            $display("FAIL R10 display_on before edge actual=%0b expected=1", display_on);
            n_bad++;
        end
        n_chk++;
        @(negedge clk);
        stb = 1'b0; byt = 8'h00;
        e_on = 1'b0; check_all("R10");
        repeat (5) @(negedge clk);
        check_all("R10");

        // R3: window sweeps
        for (int v = 0; v < 64; v++) begin
            put(1'b0, 8'h15); put(1'b0, 8'(v | 8'hC0)); put(1'b0, 8'(63 - v));
            e_cs = 6'(v); e_ce = 6'(63 - v); check_all("R3");
        end
        for (int v = 0; v < 80; v++) begin
            put(1'b0, 8'h75); put(1'b0, 8'(v | 8'h80)); put(1'b0, 8'(79 - v));
            e_rs = 7'(v); e_re = 7'(79 - v); check_all("R3");
        end

        // R4: contrast exhaustive, others single
        for (int v = 0; v < 256; v++) begin
            put(1'b0, 8'h81); put(1'b0, 8'(v)); e_ct = 7'(v & 8'h7F); check_all("R4");
        end
        put(1'b0, 8'hA0); put(1'b0, 8'hFF); e_rm = 7'h7F; check_all("R4");
        put(1'b0, 8'hA1); put(1'b0, 8'h95); e_sl = 7'h15; check_all("R4");
        put(1'b0, 8'hA2); put(1'b0, 8'hCF); e_of = 7'h4F; check_all("R4");
        put(1'b0, 8'hA8); put(1'b0, 8'h9F); e_mx = 7'h1F; check_all("R4");
        put(1'b0, 8'hAD); put(1'b0, 8'hFC); e_sp = 2'b00; check_all("R4");
        put(1'b0, 8'hBE); put(1'b0, 8'hFF); e_ch = 6'h3F; check_all("R4");
        put(1'b0, 8'hBC); put(1'b0, 8'h00); e_pc = 8'h00; check_all("R4");
        put(1'b0, 8'hCF); put(1'b0, 8'h70); e_bs = 8'h70; check_all("R4");
        put(1'b0, 8'hB2); put(1'b0, 8'hFE); e_rp = 8'hFE; check_all("R4");

        // R5: nibble splits
        put(1'b0, 8'hB1); put(1'b0, 8'hA7); e_p1 = 4'h7; e_p2 = 4'hA; check_all("R5");
        put(1'b0, 8'hB3); put(1'b0, 8'h5C); e_dv = 4'hC; e_os = 4'h5; check_all("R5");

        // R6: gray table packing, several seeds
        for (int s = 0; s < 8; s++) begin
            send_gray(8'(s), 8); check_all("R6");
        end

        // R7: data bytes ignored
        put(1'b1, 8'h81); put(1'b1, 8'h10); put(1'b1, 8'hAF); check_all("R7");

        // R8: abort mid-sequence
        put(1'b0, 8'h81); put(1'b1, 8'h22); put(1'b0, 8'hAF); e_on = 1'b1; check_all("R8");
        send_gray(8'd3, 3); put(1'b1, 8'h00); put(1'b0, 8'hA5); e_dm = 2'd1; check_all("R8");
        put(1'b0, 8'h15); put(1'b0, 8'h05); put(1'b1, 8'h3F); put(1'b0, 8'hA7);
        e_cs = 6'h05; e_dm = 2'd3; check_all("R8");

        // R9: unknown opcodes and no-op
        put(1'b0, 8'h00); check_all("R9");
        put(1'b0, 8'hE3); put(1'b0, 8'h81); put(1'b0, 8'h33); e_ct = 7'h33; check_all("R9");
        put(1'b0, 8'h87); put(1'b0, 8'hA4); e_dm = 2'd0; check_all("R9");
        put(1'b0, 8'hFF); put(1'b0, 8'hAE); e_on = 1'b0; check_all("R9");

        finish_run();
    end

endmodule